// File: doc/BRIEF.md
# Interrupt Distributor State Register Bank

This block keeps the per-line state of a set of interrupt inputs and exposes it through a 32-bit word-addressed register port. The state of each line is its enable, pending, active and group bits, an 8-bit priority, an 8-bit CPU target mask and an edge/level trigger selection. Every cycle the block samples the interrupt inputs and updates pending: a level line copies its input while it is not active, and an edge line latches a rising edge.

From the stored state the block selects one candidate for a single CPU interface. The candidate is the highest-priority line that is enabled, pending, not active and targeted at that CPU. The CPU interface answers with an acknowledge strobe, which moves a line from pending to active, and an end-of-interrupt strobe, which retires it. Enable, pending and active are changed through paired set and clear addresses, so software can change one line without a read-modify-write sequence.

Top module: `irq_state_bank`

## Requirements
- R1: After reset every state bit and field is zero: control, enable, pending, active, group, priority, target and trigger. `candValid` is 0. The type word at 0x004 reads `NUM_LINES/32 - 1` in bits [4:0], with bit 10 (security support) at 0 and all other bits at 0.
- R2: Enable, pending and active each have a set word at 0x100/0x200/0x300 and a clear word at 0x180/0x280/0x380, plus 4 per 32-line group. Bit b of word w is line 32w+b. A write changes only the bits written as 1, and reading either word of a pair returns the current state.
- R3: Group bits sit at 0x080 + 4w, bit b being line 32w+b. A write stores the written value, and a read returns it.
- R4: Priority sits at 0x400 + 4w and targets at 0x800 + 4w, with byte k (bits 8k+7:8k) holding line 4w+k. Both are read/write.
- R5: Trigger words sit at 0xC00 + 4w and cover lines 16w..16w+15. Bit 2k+1 selects edge (1) or level (0) for line 16w+k, and even bits read 0. Word 0xC00 (lines 0–15) reads 0 and ignores writes, so those lines are always level.
- R6: A level line's pending bit takes the input value each cycle while the line is not active. While it is active, pending holds.
- R7: An edge line's pending bit is set by a 0-to-1 input change and stays set after the input falls. Only an acknowledge or a pending-clear write removes it. An input held high does not set it again.
- R8: One cycle after the state changes, `candValid`/`candId`/`candPrio` name the line that is enabled, pending, not active and has target bit `CPU_SEL` set, choosing the smallest priority value. On a tie the lowest ID wins. When control bit 0 is 0, `candValid`, `candId` and `candPrio` are 0.
- R9: `ackStrobe` sets active and clears pending for line `ackId`. `eoiStrobe` clears active for line `eoiId`.
- R10: Reads return 0 and writes are ignored for words beyond the line count, for undefined offsets, and for addresses whose bits [1:0] are not 00. The type word is read-only.
- R11: A read presented with `regRdEn` returns its data on `regRdData` with `regRdValid` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address of the register word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after `regRdEn` |
| regRdValid | output | 1 | Read data valid |
| irqIn | input | NUM_LINES | Interrupt inputs, synchronous to `clk` |
| ackStrobe | input | 1 | Acknowledge from the CPU interface |
| ackId | input | log2(NUM_LINES) | Line being acknowledged |
| eoiStrobe | input | 1 | End of interrupt from the CPU interface |
| eoiId | input | log2(NUM_LINES) | Line being retired |
| candValid | output | 1 | A candidate is being offered |
| candId | output | log2(NUM_LINES) | Candidate line |
| candPrio | output | 8 | Candidate priority value |

## Verification
Corrupt pending or active state shows up at the candidate port within two cycles: a line that should be offered goes missing, or an already-active line is offered again. It also shows up in the set/clear read words on the very next read. A wrong byte lane or trigger-bit position only appears when that line competes with others, so the test places lines of equal and differing priority in different words and byte lanes. Edge lines are exercised with both a short pulse and a held-high input, so that a missing latch or a spurious re-latch becomes visible after acknowledge and end of interrupt.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int FIELD_W = 8;
  localparam int IDX_W   = 8;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_GROUP,
    RG_EN_SET, RG_EN_CLR, RG_PEND_SET, RG_PEND_CLR,
    RG_ACT_SET, RG_ACT_CLR, RG_PRIO, RG_TGT, RG_CFG
  } regionE;

  typedef struct packed {
    regionE           region;
    logic [IDX_W-1:0] wordIdx;
    logic             wr;
  } regStrobeT;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobeT         strb
);
  localparam int WORDS_1B = NUM_LINES / 32;
  localparam int WORDS_8B = NUM_LINES / 4;
  localparam int WORDS_2B = NUM_LINES / 16;

  regionE           region;
  logic [IDX_W-1:0] idx;
  int               limit;

  always_comb begin
    region = RG_NONE;
    idx    = '0;
    limit  = 1;
    casez (regAddr[11:7])
      5'b00000: begin
        if (regAddr[6:2] == 5'd0)      region = RG_CTRL;
        else if (regAddr[6:2] == 5'd1) region = RG_TYPE;
      end
      5'b00001: begin region = RG_GROUP;    idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b00010: begin region = RG_EN_SET;   idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b00011: begin region = RG_EN_CLR;   idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b00100: begin region = RG_PEND_SET; idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b00101: begin region = RG_PEND_CLR; idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b00110: begin region = RG_ACT_SET;  idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b00111: begin region = RG_ACT_CLR;  idx = {3'b000, regAddr[6:2]}; limit = WORDS_1B; end
      5'b01???: begin region = RG_PRIO;     idx = regAddr[9:2];           limit = WORDS_8B; end
      5'b10???: begin region = RG_TGT;      idx = regAddr[9:2];           limit = WORDS_8B; end
      5'b1100?: begin region = RG_CFG;      idx = {2'b00, regAddr[7:2]};  limit = WORDS_2B; end
      default:  region = RG_NONE;
    endcase
    // misaligned or beyond the configured line count: no register
    if (regAddr[1:0] != 2'b00 || int'(idx) >= limit) begin
      region = RG_NONE;
      idx    = '0;
    end
  end

  assign strb.region  = region;
  assign strb.wordIdx = idx;
  assign strb.wr      = regWrEn && (region != RG_NONE) && (region != RG_TYPE);
endmodule

// File: rtl/irq_bank_store.sv
module irq_bank_store
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int CPU_SEL   = 0,
  parameter int ID_W      = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  regStrobeT                    strb,
  input  logic [REG_W-1:0]             regWrData,
  input  logic                         regRdEn,
  input  logic [NUM_LINES-1:0]         irqIn,
  input  logic                         ackStrobe,
  input  logic [ID_W-1:0]              ackId,
  input  logic                         eoiStrobe,
  input  logic [ID_W-1:0]              eoiId,
  output logic [REG_W-1:0]             regRdData,
  output logic                         regRdValid,
  output logic                         fwdEn,
  output logic [NUM_LINES-1:0]         eligVec,
  output logic [NUM_LINES*FIELD_W-1:0] prioFlat,
  output logic [NUM_LINES-1:0]         pendVec,
  output logic [NUM_LINES-1:0]         actVec,
  output logic [NUM_LINES-1:0]         edgeVec
);
  localparam int WORDS_1B = NUM_LINES / 32;
  localparam int WORDS_8B = NUM_LINES / 4;
  localparam int WORDS_2B = NUM_LINES / 16;

  logic [NUM_LINES-1:0]         enVec;
  logic [NUM_LINES-1:0]         grpVec;
  logic [NUM_LINES*FIELD_W-1:0] tgtFlat;
  logic [2*NUM_LINES-1:0]       cfgFlat;
  logic [REG_W-1:0]             rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                fwdEn <= 1'b0;
    else if (strb.wr && strb.region == RG_CTRL) fwdEn <= regWrData[0];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int W1 = i / 32;
    localparam int B1 = i % 32;
    localparam int W8 = i / 4;
    localparam int B8 = i % 4;

    logic enR, pendR, actR, grpR, prevIn, edgeR;
    logic [FIELD_W-1:0] prioR, tgtR;
    logic wordHit1, bitHit, byteHit, ackHit, eoiHit, rise;

    assign wordHit1 = strb.wr && (int'(strb.wordIdx) == W1);
    assign bitHit   = wordHit1 && regWrData[B1];
    assign byteHit  = strb.wr && (int'(strb.wordIdx) == W8);
    assign ackHit   = ackStrobe && (int'(ackId) == i);
    assign eoiHit   = eoiStrobe && (int'(eoiId) == i);
    assign rise     = irqIn[i] && !prevIn;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR <= 1'b0; pendR <= 1'b0; actR <= 1'b0; grpR <= 1'b0;
        prevIn <= 1'b0; prioR <= '0; tgtR <= '0;
      end else begin
        prevIn <= irqIn[i];
        if (bitHit && strb.region == RG_EN_SET)      enR <= 1'b1;
        else if (bitHit && strb.region == RG_EN_CLR) enR <= 1'b0;
        if (wordHit1 && strb.region == RG_GROUP)     grpR <= regWrData[B1];
        if (byteHit && strb.region == RG_PRIO)       prioR <= regWrData[B8*FIELD_W +: FIELD_W];
        if (byteHit && strb.region == RG_TGT)        tgtR <= regWrData[B8*FIELD_W +: FIELD_W];
        // pending: acknowledge, then software clear/set, then the input
        if (ackHit)                                     pendR <= 1'b0;
        else if (bitHit && strb.region == RG_PEND_CLR)  pendR <= 1'b0;
        else if (bitHit && strb.region == RG_PEND_SET)  pendR <= 1'b1;
        else if (edgeR) begin
          if (rise) pendR <= 1'b1;
        end else if (!actR)                             pendR <= irqIn[i];
        // active: clearing wins over setting
        if (eoiHit || (bitHit && strb.region == RG_ACT_CLR))     actR <= 1'b0;
        else if (ackHit || (bitHit && strb.region == RG_ACT_SET)) actR <= 1'b1;
      end
    end

    if (i < 16) begin : g_fixed_cfg
      assign edgeR = 1'b0;
    end else begin : g_prog_cfg
      localparam int W2 = i / 16;
      localparam int B2 = i % 16;
      logic cfgHit;
      assign cfgHit = strb.wr && strb.region == RG_CFG && (int'(strb.wordIdx) == W2);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       edgeR <= 1'b0;
        else if (cfgHit) edgeR <= regWrData[2*B2+1];
      end
    end

    assign enVec[i]   = enR;
    assign pendVec[i] = pendR;
    assign actVec[i]  = actR;
    assign grpVec[i]  = grpR;
    assign edgeVec[i] = edgeR;
    assign prioFlat[i*FIELD_W +: FIELD_W] = prioR;
    assign tgtFlat[i*FIELD_W +: FIELD_W]  = tgtR;
    assign cfgFlat[2*i]   = 1'b0;
    assign cfgFlat[2*i+1] = edgeR;
    assign eligVec[i] = enR && pendR && !actR && tgtR[CPU_SEL];
  end

  always_comb begin
    rdWord = '0;
    unique case (strb.region)
      RG_CTRL: rdWord = {{(REG_W-1){1'b0}}, fwdEn};
      RG_TYPE: rdWord = REG_W'(WORDS_1B - 1);
      RG_GROUP:
        for (int w = 0; w < WORDS_1B; w++) if (int'(strb.wordIdx) == w) rdWord = grpVec[w*32 +: 32];
      RG_EN_SET, RG_EN_CLR:
        for (int w = 0; w < WORDS_1B; w++) if (int'(strb.wordIdx) == w) rdWord = enVec[w*32 +: 32];
      RG_PEND_SET, RG_PEND_CLR:
        for (int w = 0; w < WORDS_1B; w++) if (int'(strb.wordIdx) == w) rdWord = pendVec[w*32 +: 32];
      RG_ACT_SET, RG_ACT_CLR:
        for (int w = 0; w < WORDS_1B; w++) if (int'(strb.wordIdx) == w) rdWord = actVec[w*32 +: 32];
      RG_PRIO:
        for (int w = 0; w < WORDS_8B; w++) if (int'(strb.wordIdx) == w) rdWord = prioFlat[w*32 +: 32];
      RG_TGT:
        for (int w = 0; w < WORDS_8B; w++) if (int'(strb.wordIdx) == w) rdWord = tgtFlat[w*32 +: 32];
      RG_CFG:
        for (int w = 0; w < WORDS_2B; w++) if (int'(strb.wordIdx) == w) rdWord = cfgFlat[w*32 +: 32];
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= regRdEn;
      if (regRdEn) regRdData <= rdWord;
    end
  end
endmodule

// File: rtl/irq_bank_pick.sv
module irq_bank_pick
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ID_W      = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fwdEn,
  input  logic [NUM_LINES-1:0]         eligVec,
  input  logic [NUM_LINES*FIELD_W-1:0] prioFlat,
  output logic                         candValid,
  output logic [ID_W-1:0]              candId,
  output logic [FIELD_W-1:0]           candPrio
);
  logic               bestFound;
  logic [ID_W-1:0]    bestId;
  logic [FIELD_W-1:0] bestPrio;

  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    bestFound = 1'b0;
    bestId    = '0;
    bestPrio  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (eligVec[i] && (!bestFound || prioFlat[i*FIELD_W +: FIELD_W] < bestPrio)) begin
        bestFound = 1'b1;
        bestId    = ID_W'(i);
        bestPrio  = prioFlat[i*FIELD_W +: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candValid <= 1'b0;
      candId    <= '0;
      candPrio  <= '0;
    end else begin
      candValid <= fwdEn && bestFound;
      candId    <= (fwdEn && bestFound) ? bestId : '0;
      candPrio  <= (fwdEn && bestFound) ? bestPrio : '0;
    end
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int CPU_SEL   = 0,
  localparam int ID_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic                 regRdValid,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 ackStrobe,
  input  logic [ID_W-1:0]      ackId,
  input  logic                 eoiStrobe,
  input  logic [ID_W-1:0]      eoiId,
  output logic                 candValid,
  output logic [ID_W-1:0]      candId,
  output logic [FIELD_W-1:0]   candPrio
);
  if (NUM_LINES % 32 != 0 || NUM_LINES < 32 || NUM_LINES > 992 || CPU_SEL < 0 || CPU_SEL > 7)
  begin : g_bad_param
    $error("irq_state_bank: unsupported NUM_LINES or CPU_SEL");
  end

  regStrobeT                    strb;
  logic                         fwdEn;
  logic [NUM_LINES-1:0]         eligVec;
  logic [NUM_LINES-1:0]         pendVec;
  logic [NUM_LINES-1:0]         actVec;
  logic [NUM_LINES-1:0]         edgeVec;
  logic [NUM_LINES*FIELD_W-1:0] prioFlat;

  irq_bank_decode #(.NUM_LINES(NUM_LINES)) u_decode (
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  irq_bank_store #(.NUM_LINES(NUM_LINES), .CPU_SEL(CPU_SEL), .ID_W(ID_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData), .regRdEn(regRdEn),
    .irqIn(irqIn), .ackStrobe(ackStrobe), .ackId(ackId), .eoiStrobe(eoiStrobe), .eoiId(eoiId),
    .regRdData(regRdData), .regRdValid(regRdValid), .fwdEn(fwdEn), .eligVec(eligVec),
    .prioFlat(prioFlat), .pendVec(pendVec), .actVec(actVec), .edgeVec(edgeVec)
  );

  irq_bank_pick #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_pick (
    .clk(clk), .rstN(rstN), .fwdEn(fwdEn), .eligVec(eligVec), .prioFlat(prioFlat),
    .candValid(candValid), .candId(candId), .candPrio(candPrio)
  );
endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker #(
  parameter int NUM_LINES = 64,
  parameter int ID_W      = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic                 ackStrobe,
  input logic [ID_W-1:0]      ackId,
  input logic                 eoiStrobe,
  input logic [ID_W-1:0]      eoiId,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 candValid,
  input logic [ID_W-1:0]      candId,
  input logic                 fwdEn,
  input logic [NUM_LINES-1:0] eligVec,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] actVec,
  input logic [NUM_LINES-1:0] edgeVec
);
  logic [NUM_LINES-1:0] prevElig;
  logic [ID_W-1:0]      lastAckId;
  logic [ID_W-1:0]      lastEoiId;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevElig  <= '0;
      lastAckId <= '0;
      lastEoiId <= '0;
    end else begin
      prevElig  <= eligVec;
      lastAckId <= ackId;
      lastEoiId <= eoiId;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!candValid && pendVec == '0 && actVec == '0));

  assert_cand_eligible_R8: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> prevElig[candId]);

  assert_fwd_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(fwdEn) |-> !candValid);

  assert_ack_moves_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !eoiStrobe && !regWrEn) |=> (actVec[lastAckId] && !pendVec[lastAckId]));

  assert_eoi_retires_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStrobe && !ackStrobe && !regWrEn) |=> !actVec[lastEoiId]);

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !ackStrobe) |=>
      (((pendVec ^ $past(irqIn)) & ~$past(edgeVec) & ~$past(actVec)) == '0));

  assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !ackStrobe) |=> (($past(pendVec) & $past(edgeVec) & ~pendVec) == '0));
endmodule

bind irq_state_bank irq_bank_checker #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .ackStrobe(ackStrobe), .ackId(ackId),
  .eoiStrobe(eoiStrobe), .eoiId(eoiId), .irqIn(irqIn), .candValid(candValid),
  .candId(candId), .fwdEn(fwdEn), .eligVec(eligVec), .pendVec(pendVec),
  .actVec(actVec), .edgeVec(edgeVec)
);

// File: tb/irq_state_bank_test.sv
module irq_state_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic [LINES-1:0] irqIn = '0;
  logic        ackStrobe = 1'b0;
  logic [5:0]  ackId = '0;
  logic        eoiStrobe = 1'b0;
  logic [5:0]  eoiId = '0;
  logic        candValid;
  logic [5:0]  candId;
  logic [7:0]  candPrio;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_state_bank #(.NUM_LINES(LINES), .CPU_SEL(0)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regRdValid(regRdValid), .irqIn(irqIn),
    .ackStrobe(ackStrobe), .ackId(ackId), .eoiStrobe(eoiStrobe), .eoiId(eoiId),
    .candValid(candValid), .candId(candId), .candPrio(candPrio)
  );

  // monitor: pops the expected read value when the design returns data
  always @(negedge clk) begin
    if (regRdValid) begin
      testsRun++;
      if (expQ.size() == 0) begin
        testsFailed++;
        $display("FAIL R11 unexpected read data: got %h expected none", regRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdData !== e) begin
          testsFailed++;
          $display("FAIL %s: got %h expected %h", t, regRdData, e);
        end
      end
    end
  end

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(t);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic checkCand(input logic v, input logic [5:0] id, input logic [7:0] p, input string t);
    testsRun++;
    if (candValid !== v || candId !== id || candPrio !== p) begin
      testsFailed++;
      $display("FAIL %s: got v=%0b id=%0d prio=%h expected v=%0b id=%0d prio=%h",
               t, candValid, candId, candPrio, v, id, p);
    end
  endtask

  task automatic pulseAck(input logic [5:0] id);
    @(negedge clk); ackStrobe = 1'b1; ackId = id;
    @(negedge clk); ackStrobe = 1'b0;
  endtask

  task automatic pulseEoi(input logic [5:0] id);
    @(negedge clk); eoiStrobe = 1'b1; eoiId = id;
    @(negedge clk); eoiStrobe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    checkCand(1'b0, 6'd0, 8'h00, "R1 candidate idle after reset");
    expectRead(12'h004, 32'h0000_0001, "R1 type word line count");
    expectRead(12'h000, 32'h0, "R1 control reset");
    expectRead(12'h100, 32'h0, "R1 enable reset");
    expectRead(12'h400, 32'h0, "R1 priority reset");
    expectRead(12'h800, 32'h0, "R1 target reset");
    // R3 group
    wrReg(12'h084, 32'hA5A5_0001);
    expectRead(12'h084, 32'hA5A5_0001, "R3 group word 1");
    expectRead(12'h080, 32'h0, "R3 group word 0 untouched");
    // R4 priority and target byte lanes
    wrReg(12'h404, 32'h1122_3344);
    expectRead(12'h404, 32'h1122_3344, "R4 priority lanes");
    wrReg(12'h80C, 32'h0102_0408);
    expectRead(12'h80C, 32'h0102_0408, "R4 target lanes");
    // R10 out-of-range, undefined, misaligned, read-only
    wrReg(12'h088, 32'hFFFF_FFFF);
    expectRead(12'h088, 32'h0, "R10 group word beyond lines");
    expectRead(12'h440, 32'h0, "R10 priority beyond lines");
    wrReg(12'h004, 32'h0000_001F);
    expectRead(12'h004, 32'h0000_0001, "R10 type read-only");
    expectRead(12'h008, 32'h0, "R10 undefined offset");
    wrReg(12'h101, 32'hFFFF_FFFF);
    expectRead(12'h100, 32'h0, "R10 misaligned write ignored");
    // R5 trigger words
    wrReg(12'hC00, 32'hFFFF_FFFF);
    expectRead(12'hC00, 32'h0, "R5 lines 0-15 fixed level");
    wrReg(12'hC04, 32'hFFFF_FFFF);
    expectRead(12'hC04, 32'hAAAA_AAAA, "R5 odd bits only");
    expectRead(12'hC10, 32'h0, "R10 trigger word beyond lines");
    wrReg(12'hC04, 32'h0000_0008);
    expectRead(12'hC04, 32'h0000_0008, "R5 line 17 edge");
    // R2 set/clear aliases
    wrReg(12'h100, 32'h0000_00F0);
    expectRead(12'h100, 32'h0000_00F0, "R2 enable set");
    wrReg(12'h100, 32'h0000_0003);
    expectRead(12'h100, 32'h0000_00F3, "R2 enable set keeps others");
    wrReg(12'h180, 32'h0000_0021);
    expectRead(12'h180, 32'h0000_00D2, "R2 enable clear via clear word");
    expectRead(12'h100, 32'h0000_00D2, "R2 enable clear via set word");
    wrReg(12'h304, 32'h8000_0001);
    expectRead(12'h384, 32'h8000_0001, "R2 active set");
    wrReg(12'h384, 32'h0000_0001);
    expectRead(12'h304, 32'h8000_0000, "R2 active clear");
    wrReg(12'h200, 32'h0002_0000);
    expectRead(12'h200, 32'h0002_0000, "R2 pending set edge line");
    expectRead(12'h280, 32'h0002_0000, "R2 pending read via clear word");
    wrReg(12'h280, 32'h0002_0000);
    expectRead(12'h200, 32'h0, "R2 pending clear");

    // candidate phase
    doReset();
    wrReg(12'h000, 32'h1);
    wrReg(12'h400, 32'h40A0_A0A0);
    wrReg(12'h404, 32'hA0A0_40A0);
    wrReg(12'h410, 32'h0000_2000);
    wrReg(12'h420, 32'h0000_1000);
    wrReg(12'h800, 32'h0101_0101);
    wrReg(12'h804, 32'h0101_0101);
    wrReg(12'h810, 32'h0101_0101);
    wrReg(12'h820, 32'h0101_0201);
    wrReg(12'h100, 32'h0000_0028);
    wrReg(12'h104, 32'h0000_0002);
    @(negedge clk); irqIn[3] = 1'b1; irqIn[5] = 1'b1;
    settle();
    checkCand(1'b1, 6'd3, 8'h40, "R8 tie goes to lowest id");
    expectRead(12'h200, 32'h0000_0028, "R6 level pending follows input");
    @(negedge clk); irqIn[3] = 1'b0;
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R6 level pending drops with input");
    @(negedge clk); irqIn[33] = 1'b1;
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R8 target bit excludes line 33");
    wrReg(12'h820, 32'h0101_0101);
    settle();
    checkCand(1'b1, 6'd33, 8'h10, "R8 lowest priority value wins");
    wrReg(12'h000, 32'h0);
    settle();
    checkCand(1'b0, 6'd0, 8'h00, "R8 forwarding disabled");
    wrReg(12'h000, 32'h1);
    settle();
    checkCand(1'b1, 6'd33, 8'h10, "R8 forwarding re-enabled");
    pulseAck(6'd33);
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R9 acknowledged line leaves candidacy");
    expectRead(12'h304, 32'h0000_0002, "R9 acknowledge sets active");
    expectRead(12'h204, 32'h0, "R6 level pending held while active");
    pulseEoi(6'd33);
    settle();
    checkCand(1'b1, 6'd33, 8'h10, "R9 end of interrupt re-arms level line");
    expectRead(12'h304, 32'h0, "R9 end of interrupt clears active");
    @(negedge clk); irqIn[33] = 1'b0;
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R6 level line 33 released");
    // R7 edge line 17
    wrReg(12'hC04, 32'h0000_0008);
    wrReg(12'h100, 32'h0002_0000);
    @(negedge clk); irqIn[17] = 1'b1;
    @(negedge clk); irqIn[17] = 1'b0;
    settle();
    checkCand(1'b1, 6'd17, 8'h20, "R7 edge pulse latched after input falls");
    pulseAck(6'd17);
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R7 acknowledge removes edge pending");
    expectRead(12'h200, 32'h0000_0020, "R7 edge pending cleared by acknowledge");
    pulseEoi(6'd17);
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R7 no re-pend without new edge");
    @(negedge clk); irqIn[17] = 1'b1;
    settle();
    checkCand(1'b1, 6'd17, 8'h20, "R7 rising edge held high latches");
    pulseAck(6'd17);
    pulseEoi(6'd17);
    settle();
    checkCand(1'b1, 6'd5, 8'h40, "R7 input held high does not re-pend");

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R11 missing read data: got %0d outstanding expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule